// File: doc/BRIEF.md
# Programmable Power-of-Two Reference Clock Divider Bank

This block derives slow auxiliary clocks from a reference crystal clock. It holds several identical divider units. Each unit produces a divided clock whose ratio is a power of two from 1 to 64. The divided clock is meant to be routed out to a general-purpose pin. Software reaches every unit through one byte-wide register port that runs on the reference clock. Each unit has one register that holds a 3-bit ratio exponent and one register that holds an output-enable bit. The units repeat at a fixed address stride.

Turning an output on or off never produces a truncated pulse. The enable bit passes through a synchronizer into the divider domain. The divider then starts or stops its output only while the output is low. Both transitions finish within a bound that grows with the ratio. A unit captures a new ratio code only while it is fully stopped. A code written while the unit runs therefore waits until the next disable and re-enable.

Top module: `clkdiv_bank`

## Requirements
- R1: One cycle after a reset cycle, every divided output is low and the read data is 0x00. Every ratio code and enable bit is cleared by reset.
- R2: Unit u sits at byte address u*0x100. Its ratio code is bits [2:0] at offset 0x43. Its enable is bit 7 at offset 0x46. A read with `reg_rd` high returns, one cycle later, the last value written to the implemented bits, and 0 in every other bit. A read of any other offset returns 0x00, and a write to any other offset changes nothing.
- R3: Code c selects the ratio 2^(c-1). Code 0 acts as code 1 (ratio 1), and code 7 gives ratio 64. The output period equals the ratio in reference cycles.
- R4: For ratio 2 or more, the output stays high for ratio/2 reference cycles and then low for ratio/2 reference cycles. For ratio 1, the output follows the reference clock while the unit is enabled.
- R5: After the write that sets the enable bit, the first rising edge of the output comes within 2+3*ratio reference cycles.
- R6: After the write that clears the enable bit, the output is low within 3*ratio reference cycles and stays low.
- R7: Every high pulse has the full width of a half period. Starting or stopping never shortens one.
- R8: Each unit has its own code and enable bit. Traffic to one unit leaves the output and registers of every other unit unchanged.
- R9: A code written while a unit is enabled shows up at once on readback. The output keeps the ratio it was started with until the unit has been disabled and enabled again.
- R10: A unit index at or above the number of units is not mapped. Writes to it have no effect on any output, and reads from it return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; it clocks both the register port and the dividers |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe of the register port |
| reg_rd | input | 1 | Read strobe; the data appears on `reg_rdata` in the following cycle |
| reg_addr | input | ADDR_W | Byte address: unit index in the bits above bit 7, register offset in bits [7:0] |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data; 0x00 in cycles that follow no read |
| div_clk_o | output | N_UNITS | One divided clock per unit |

## Verification
A bound checker watches the register port on every cycle. It checks readback of both fields, that the unimplemented bits stay zero, that unmapped units read zero and that reset clears everything. It also puts an upper bound on how long any output stays high. The exact pulse widths and periods can only be shown by the bench. The same holds for the start and stop latencies against their ratio-dependent bounds, the pass-through at ratio 1, the deferred code change and the independence of the units. The bench measures these by sampling every output twice per reference cycle, against a behavioural model of the expected widths.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CODE_W   = 3;
  localparam int MAX_HALF = 32;
  localparam int HALF_W   = $clog2(MAX_HALF);

  localparam logic [7:0] OFS_DIV = 8'h43;
  localparam logic [7:0] OFS_ENA = 8'h46;
  localparam int         ENA_BIT = 7;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              ena;
  } unit_cfg_t;

  // Half period minus one, in reference cycles, for codes with ratio >= 2.
  function automatic logic [HALF_W-1:0] half_m1(input logic [CODE_W-1:0] c);
    int sh;
    if (c < 3'd2) return '0;
    sh = int'(c) - 2;
    return HALF_W'((1 << sh) - 1);
  endfunction

  // Codes 0 and 1 both mean "no division".
  function automatic logic is_bypass(input logic [CODE_W-1:0] c);
    return (c <= 3'd1);
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int N_UNITS = 3,
  parameter int ADDR_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output unit_cfg_t [N_UNITS-1:0] cfg
);
  localparam int UIDX_W = ADDR_W - 8;

  logic [UIDX_W-1:0] uidx;
  logic [7:0]        offs;
  logic [7:0]        rd_mux;

  assign uidx = addr[ADDR_W-1:8];
  assign offs = addr[7:0];

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    localparam logic [UIDX_W-1:0] MY_IDX = UIDX_W'(i);
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[i] <= '0;
      end else if (wr && uidx == MY_IDX) begin
        if (offs == OFS_DIV) cfg[i].code <= wdata[CODE_W-1:0];
        if (offs == OFS_ENA) cfg[i].ena  <= wdata[ENA_BIT];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_UNITS; i++) begin
      if (uidx == UIDX_W'(i)) begin
        if (offs == OFS_DIV) rd_mux = {{(8-CODE_W){1'b0}}, cfg[i].code};
        if (offs == OFS_ENA) rd_mux = {cfg[i].ena, 7'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
    else         rdata <= '0;
  end
endmodule

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ena_s,
  input  logic [CODE_W-1:0] code,
  output logic              div_o
);
  logic [CODE_W-1:0] act_code;
  logic [HALF_W-1:0] cnt;
  logic              run_q;
  logic              out_q;
  logic              gate_n;
  logic              bypass;
  logic [HALF_W-1:0] last;

  assign bypass = is_bypass(act_code);
  assign last   = half_m1(act_code);

  // Divide path: toggle every half period, start and stop only while low.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_code <= '0;
      cnt      <= '0;
      run_q    <= 1'b0;
      out_q    <= 1'b0;
    end else begin
      if (!ena_s && !run_q && !gate_n) act_code <= code;
      if (!run_q) begin
        out_q <= 1'b0;
        cnt   <= '0;
        if (ena_s && !bypass) run_q <= 1'b1;
      end else if (!ena_s && !out_q) begin
        run_q <= 1'b0;
        cnt   <= '0;
      end else if (cnt == last) begin
        cnt   <= '0;
        out_q <= ~out_q;
        if (!ena_s && out_q) run_q <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Pass-through path: gate changes only while the reference clock is low.
  always_ff @(negedge clk) begin
    if (rst) gate_n <= 1'b0;
    else     gate_n <= ena_s && bypass && !run_q;
  end

  assign div_o = bypass ? (clk & gate_n) : out_q;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int N_UNITS     = 3,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic [N_UNITS-1:0] div_clk_o
);
  unit_cfg_t [N_UNITS-1:0] cfg;

  clkdiv_regs #(.N_UNITS(N_UNITS), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .rd    (reg_rd),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  for (genvar i = 0; i < N_UNITS; i++) begin : g_div
    logic ena_s;

    clkdiv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (cfg[i].ena),
      .q   (ena_s)
    );

    clkdiv_core u_core (
      .clk   (clk),
      .rst   (rst),
      .ena_s (ena_s),
      .code  (cfg[i].code),
      .div_o (div_clk_o[i])
    );
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int N_UNITS = 3,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [7:0]         reg_wdata,
  input logic [7:0]         reg_rdata,
  input logic [N_UNITS-1:0] div_clk_o
);
  logic mapped;
  assign mapped = int'(reg_addr[ADDR_W-1:8]) < N_UNITS;

  assert_rst_clear_R1: assert property (@(posedge clk)
    rst |=> (reg_rdata == 8'h00 && div_clk_o == '0));

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[6:3] == 4'h0);

  assert_code_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && mapped && reg_addr[7:0] == 8'h43) ##1
    (reg_rd && !reg_wr && $stable(reg_addr))
    |=> reg_rdata == {5'b0, $past(reg_wdata[2:0], 2)});

  assert_ena_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && mapped && reg_addr[7:0] == 8'h46) ##1
    (reg_rd && !reg_wr && $stable(reg_addr))
    |=> reg_rdata == {$past(reg_wdata[7], 2), 7'b0});

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !mapped) |=> reg_rdata == 8'h00);

  for (genvar i = 0; i < N_UNITS; i++) begin : g_hi
    logic [6:0] hcnt;
    always_ff @(posedge clk) begin
      if (rst)               hcnt <= '0;
      else if (div_clk_o[i]) hcnt <= hcnt + 1'b1;
      else                   hcnt <= '0;
    end
    assert_high_bounded_R4: assert property (@(posedge clk) disable iff (rst)
      hcnt <= 7'd32);
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.N_UNITS(N_UNITS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .div_clk_o (div_clk_o)
);

// File: tb/clkdiv_bank_test.sv
`timescale 1ns/1ps
module clkdiv_bank_test;
  localparam int CLK_P = 20;
  localparam int N     = 3;
  localparam int AW    = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [N-1:0]  div_clk_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Behavioural monitor state, widths in half reference cycles.
  int     hi_run[N], lo_run[N], exp_r[N], rises[N], last_hi_w[N], last_lo_w[N];
  bit     prev[N], gap_ok[N];
  longint last_rise[N], last_fall[N];

  always #(CLK_P/2) clk = ~clk;

  clkdiv_bank #(.N_UNITS(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .div_clk_o(div_clk_o)
  );

  task automatic check(input bit ok, input string msg, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic sample();
    for (int u = 0; u < N; u++) begin
      bit s;
      s = div_clk_o[u];
      if (rst) begin
        prev[u] = 1'b0;
        continue;
      end
      if (s && !prev[u]) begin
        if (gap_ok[u]) begin
          last_lo_w[u] = lo_run[u];
          check(lo_run[u] == exp_r[u], $sformatf("R4 low phase unit%0d", u), lo_run[u], exp_r[u]);
        end
        gap_ok[u]    = 1'b1;
        hi_run[u]    = 1;
        rises[u]++;
        last_rise[u] = $time - CLK_P/4;
      end else if (s) begin
        hi_run[u]++;
      end else if (prev[u]) begin
        last_hi_w[u] = hi_run[u];
        check(hi_run[u] == exp_r[u], $sformatf("R7 high pulse unit%0d", u), hi_run[u], exp_r[u]);
        lo_run[u]    = 1;
        last_fall[u] = $time - CLK_P/4;
      end else begin
        lo_run[u]++;
      end
      prev[u] = s;
    end
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    sample();
    #(CLK_P/2);
    sample();
  end

  task automatic wr(input int u, input logic [7:0] off, input logic [7:0] d, output longint tw);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = AW'(u * 256 + int'(off));
    reg_wdata = d;
    @(posedge clk);
    tw = $time;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int u, input logic [7:0] off, output logic [7:0] d);
    @(negedge clk);
    reg_rd   = 1'b1;
    reg_addr = AW'(u * 256 + int'(off));
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic int ratio_of(input int code);
    return (code == 0) ? 1 : (1 << (code - 1));
  endfunction

  task automatic start_unit(input int u, input int code);
    longint tw;
    int r, r0;
    r = ratio_of(code);
    wr(u, 8'h43, 8'(code), tw);
    exp_r[u]  = r;
    gap_ok[u] = 1'b0;
    r0 = rises[u];
    wr(u, 8'h46, 8'h80, tw);
    for (int k = 0; k < 3 * r + 8 && rises[u] == r0; k++) @(posedge clk);
    @(negedge clk);
    check(rises[u] > r0, $sformatf("R5 output started unit%0d", u), rises[u], r0 + 1);
    if (rises[u] > r0)
      check((last_rise[u] - tw) / CLK_P <= 2 + 3 * r, $sformatf("R5 on latency unit%0d", u),
            (last_rise[u] - tw) / CLK_P, 2 + 3 * r);
  endtask

  task automatic wait_pulses(input int u, input int n, input int r, input string tag);
    int r0;
    r0 = rises[u];
    for (int k = 0; k < (n + 2) * r * 2 + 10 && rises[u] < r0 + n; k++) @(posedge clk);
    @(negedge clk);
    check(rises[u] >= r0 + n, {tag, " R3 pulse count"}, rises[u] - r0, n);
    check(last_hi_w[u] == r, {tag, " R4 high width"}, last_hi_w[u], r);
    check(last_lo_w[u] == r, {tag, " R4 low width"}, last_lo_w[u], r);
    check(last_hi_w[u] + last_lo_w[u] == 2 * r, {tag, " R3 period"},
          last_hi_w[u] + last_lo_w[u], 2 * r);
  endtask

  task automatic stop_unit(input int u, input int r);
    longint tw;
    wr(u, 8'h46, 8'h00, tw);
    repeat (3 * r + 10) @(posedge clk);
    @(negedge clk);
    check(last_fall[u] <= tw + 3 * r * CLK_P, $sformatf("R6 off latency unit%0d", u),
          (last_fall[u] - tw) / CLK_P, 3 * r);
    check(last_rise[u] < last_fall[u] && div_clk_o[u] == 1'b0,
          $sformatf("R6 output held low unit%0d", u), div_clk_o[u], 0);
  endtask

  initial begin
    logic [7:0] d;
    longint tw;
    int r_before;
    for (int u = 0; u < N; u++) begin
      hi_run[u] = 0; lo_run[u] = 0; exp_r[u] = 0; rises[u] = 0;
      last_hi_w[u] = 0; last_lo_w[u] = 0; prev[u] = 0; gap_ok[u] = 0;
      last_rise[u] = -1; last_fall[u] = -1;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(div_clk_o == '0, "R1 outputs low after reset", div_clk_o, 0);
    for (int u = 0; u < N; u++) begin
      rd(u, 8'h43, d);
      check(d == 8'h00, "R1 ratio code cleared", d, 0);
      rd(u, 8'h46, d);
      check(d == 8'h00, "R1 enable cleared", d, 0);
    end

    // R2: field positions and unused bits
    wr(0, 8'h43, 8'hFF, tw);
    rd(0, 8'h43, d);
    check(d == 8'h07, "R2 code readback", d, 8'h07);
    wr(1, 8'h46, 8'h7F, tw);
    rd(1, 8'h46, d);
    check(d == 8'h00, "R2 enable ignores low bits", d, 0);
    wr(0, 8'h44, 8'hA5, tw);
    rd(0, 8'h44, d);
    check(d == 8'h00, "R2 other offset reads zero", d, 0);
    rd(0, 8'h43, d);
    check(d == 8'h07, "R2 other offset write harmless", d, 8'h07);

    // R10: unmapped unit
    wr(N, 8'h43, 8'h03, tw);
    wr(N, 8'h46, 8'h80, tw);
    rd(N, 8'h46, d);
    check(d == 8'h00, "R10 unmapped enable reads zero", d, 0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(rises[0] + rises[1] + rises[2] == 0, "R10 no output started",
          rises[0] + rises[1] + rises[2], 0);
    wr(N, 8'h46, 8'h00, tw);

    // R3 R4: ratios across codes, including code 0 and code 7
    start_unit(0, 0); wait_pulses(0, 6, 1, "code0"); stop_unit(0, 1);
    start_unit(0, 1); wait_pulses(0, 6, 1, "code1"); stop_unit(0, 1);
    start_unit(1, 2); wait_pulses(1, 5, 2, "code2"); stop_unit(1, 2);
    start_unit(2, 3); wait_pulses(2, 4, 4, "code3"); stop_unit(2, 4);
    start_unit(2, 7); wait_pulses(2, 3, 64, "code7"); stop_unit(2, 64);

    // R8: two units run together with different ratios
    start_unit(1, 3);
    start_unit(0, 2);
    wait_pulses(0, 5, 2, "R8 unit0");
    r_before = rises[1];
    wr(0, 8'h43, 8'h06, tw);
    rd(1, 8'h43, d);
    check(d == 8'h03, "R8 unit1 code untouched", d, 3);
    stop_unit(0, 2);
    wait_pulses(1, 3, 4, "R8 unit1");
    check(rises[1] > r_before, "R8 unit1 kept running", rises[1], r_before + 1);
    stop_unit(1, 4);

    // R9: code change while running is deferred
    start_unit(0, 2);
    wr(0, 8'h43, 8'h05, tw);
    rd(0, 8'h43, d);
    check(d == 8'h05, "R9 new code visible on readback", d, 5);
    wait_pulses(0, 6, 2, "R9 old ratio kept");
    stop_unit(0, 2);
    start_unit(0, 5);
    wait_pulses(0, 3, 16, "R9 new ratio after restart");
    stop_unit(0, 16);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule